// File: doc/BRIEF.md
# Integer-to-Float Converter with Rounding

This is a purely combinational converter. It takes a 64-bit operand, reads it as a signed or unsigned integer of 32 or 64 bits, and produces a binary64 encoding of that value. A precision select asks for a single-precision result instead. The value is then rounded to a 24-bit significand and the binary32 value is delivered widened into binary64 format. Rounding uses the dynamic rounding mode supplied with each operation.

The block reports whether rounding increased the magnitude, whether any bits were lost, an inexact summary, and a 5-bit class of the rounded result. A 32-bit integer converted to double precision can never lose bits. For that case the block drops `status_update`, which tells the surrounding status logic to leave its flags and class alone. All other conversions raise `status_update` and the flags and class are valid. Trapping and register writeback belong to the surrounding pipeline.

Top module: `int2fp_cvt`

## Requirements
- R1: `int_kind` selects the source type: 0 signed 32-bit, 1 unsigned 32-bit, 2 signed 64-bit, 3 unsigned 64-bit. For kinds 0 and 1 only `int_in[31:0]` is used, and the upper 32 bits have no effect on any output.
- R2: With `int_kind` 0 or 1 and `single_prec` = 0, the result is exact. In that case `status_update` = 0, and `frac_rounded`, `frac_inexact`, `inexact_sum` and `fp_class` are all 0.
- R3: For a 64-bit kind, or whenever `single_prec` = 1, `status_update` = 1.
- R4: `rnd_mode` encodes 00 nearest-even, 01 toward zero, 10 toward +infinity and 11 toward -infinity. Rounding applies at bit 53 of the significand for double precision and at bit 24 for single precision.
- R5: `frac_rounded` is 1 exactly when rounding increased the magnitude of the result.
- R6: `frac_inexact` is 1 exactly when nonzero bits were discarded. `inexact_sum` always equals `frac_inexact`.
- R7: With `single_prec` = 1, the binary32-rounded value is delivered exactly as binary64, so fraction bits [28:0] of `fp_out` are zero.
- R8: `fp_class` is 00010 for +zero, 01000 for a negative normal and 00100 for a positive normal. The class is taken from the rounded result.
- R9: A zero operand gives +0.0 (all bits zero). The most negative signed value converts exactly to -2^31 or -2^63, with no inexact flag.
- R10: When rounding up carries out of the significand, the exponent increments and the fraction becomes zero. For example, all-ones unsigned 64-bit rounded up gives 2^64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| int_in | input | 64 | Integer operand |
| int_kind | input | 2 | Source integer type select |
| single_prec | input | 1 | 1 = round to binary32 precision |
| rnd_mode | input | 2 | Dynamic rounding mode |
| fp_out | output | 64 | binary64 result |
| status_update | output | 1 | Flags and class are valid and should be written |
| frac_rounded | output | 1 | Magnitude increased by rounding |
| frac_inexact | output | 1 | Nonzero bits discarded |
| inexact_sum | output | 1 | Inexact summary |
| fp_class | output | 5 | Class of the rounded result |

## Verification
The bound checker watches invariants that must hold for every input. The exact 32-bit double path must stay silent, and any non-exact path must request a status update. The summary flag must mirror the inexact flag, a magnitude increase must imply inexactness, and single results must carry a clear low fraction. The class must agree with the sign and zero-ness of the output word. Only the directed scenarios can show the numeric values themselves: correct rounding in each of the four modes, including ties, negative operands under directed rounding, and the carry into the exponent. They also show that the upper operand half is ignored for 32-bit kinds, which the invariants cannot see.

// File: rtl/int2fp_cvt.sv
module int2fp_cvt (
  input  logic [63:0] int_in,
  input  logic [1:0]  int_kind,
  input  logic        single_prec,
  input  logic [1:0]  rnd_mode,
  output logic [63:0] fp_out,
  output logic        status_update,
  output logic        frac_rounded,
  output logic        frac_inexact,
  output logic        inexact_sum,
  output logic [4:0]  fp_class
);
  localparam int DMANT = 53;
  localparam int SMANT = 24;
  localparam int EXPW  = 11;
  localparam int BIAS  = 1023;
  localparam int SPAD  = DMANT - SMANT;

  logic narrow, is_signed, neg, zero;
  logic [63:0] ext, mag, norm;
  logic [6:0] lz;

  assign narrow    = ~int_kind[1];
  assign is_signed = ~int_kind[0];
  assign ext = narrow ? (is_signed ? {{32{int_in[31]}}, int_in[31:0]} : {32'b0, int_in[31:0]})
                      : int_in;
  assign neg  = is_signed & ext[63];
  assign mag  = neg ? (~ext + 64'd1) : ext;
  assign zero = (mag == 64'd0);

  always_comb begin
    lz = 7'd64;
    for (int i = 0; i < 64; i++)
      if (mag[i]) lz = 7'(63 - i);
  end

  assign norm = mag << lz[5:0];

  logic [DMANT-1:0] d_keep;
  logic [SMANT-1:0] s_keep;
  logic d_guard, d_stick, s_guard, s_stick;
  assign d_keep  = norm[63 -: DMANT];
  assign d_guard = norm[63-DMANT];
  assign d_stick = |norm[62-DMANT:0];
  assign s_keep  = norm[63 -: SMANT];
  assign s_guard = norm[63-SMANT];
  assign s_stick = |norm[62-SMANT:0];

  logic lsb, guard, stick, inexact, up;
  assign lsb     = single_prec ? s_keep[0] : d_keep[0];
  assign guard   = single_prec ? s_guard   : d_guard;
  assign stick   = single_prec ? s_stick   : d_stick;
  assign inexact = guard | stick;

  always_comb begin
    case (rnd_mode)
      2'b00:   up = guard & (stick | lsb);
      2'b01:   up = 1'b0;
      2'b10:   up = inexact & ~neg;
      default: up = inexact & neg;
    endcase
  end

  logic [DMANT:0] d_sum;
  logic [SMANT:0] s_sum;
  logic carry;
  logic [DMANT-2:0] frac;
  logic [EXPW-1:0] expo;
  assign d_sum = {1'b0, d_keep} + (DMANT+1)'(up);
  assign s_sum = {1'b0, s_keep} + (SMANT+1)'(up);
  assign carry = single_prec ? s_sum[SMANT] : d_sum[DMANT];
  assign frac  = single_prec ? {s_sum[SMANT-2:0], {SPAD{1'b0}}} : d_sum[DMANT-2:0];
  assign expo  = EXPW'(BIAS) + EXPW'(7'd63 - lz) + EXPW'(carry);

  assign fp_out        = zero ? 64'd0 : {neg, expo, frac};
  assign status_update = ~(narrow & ~single_prec);
  assign frac_rounded  = status_update & up;
  assign frac_inexact  = status_update & inexact;
  assign inexact_sum   = frac_inexact;
  assign fp_class      = !status_update ? 5'b00000 :
                         zero           ? 5'b00010 :
                         neg            ? 5'b01000 : 5'b00100;
endmodule

// File: rtl/int2fp_cvt_chk.sv
module int2fp_cvt_chk (
  input logic [1:0]  int_kind,
  input logic        single_prec,
  input logic [63:0] fp_out,
  input logic        status_update,
  input logic        frac_rounded,
  input logic        frac_inexact,
  input logic        inexact_sum,
  input logic [4:0]  fp_class
);
  always_comb begin
    assert_exact_quiet_R2: assert (!(!int_kind[1] && !single_prec) ||
      (!status_update && !frac_rounded && !frac_inexact && fp_class == 5'b0))
      else $error("exact path raised status");
    assert_update_R3: assert (!(int_kind[1] || single_prec) || status_update)
      else $error("status_update missing");
    assert_rounded_inexact_R5: assert (!frac_rounded || frac_inexact)
      else $error("rounded without inexact");
    assert_summary_R6: assert (inexact_sum == frac_inexact)
      else $error("summary mismatch");
    assert_single_low_R7: assert (!single_prec || fp_out[28:0] == 29'b0)
      else $error("single low fraction nonzero");
    assert_class_R8: assert (!status_update ||
      fp_class == ((fp_out == 64'd0) ? 5'b00010 : (fp_out[63] ? 5'b01000 : 5'b00100)))
      else $error("class mismatch");
  end
endmodule

bind int2fp_cvt int2fp_cvt_chk u_chk (
  .int_kind(int_kind), .single_prec(single_prec), .fp_out(fp_out),
  .status_update(status_update), .frac_rounded(frac_rounded),
  .frac_inexact(frac_inexact), .inexact_sum(inexact_sum), .fp_class(fp_class)
);

// File: tb/int2fp_cvt_test.sv
module int2fp_cvt_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [63:0] int_in;
  logic [1:0]  int_kind, rnd_mode;
  logic        single_prec;
  logic [63:0] fp_out;
  logic        status_update, frac_rounded, frac_inexact, inexact_sum;
  logic [4:0]  fp_class;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  int2fp_cvt uut (
    .int_in(int_in), .int_kind(int_kind), .single_prec(single_prec), .rnd_mode(rnd_mode),
    .fp_out(fp_out), .status_update(status_update), .frac_rounded(frac_rounded),
    .frac_inexact(frac_inexact), .inexact_sum(inexact_sum), .fp_class(fp_class)
  );

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic apply(input logic [63:0] v, input logic [1:0] k, input logic sp, input logic [1:0] rm);
    @(posedge clk);
    int_in = v; int_kind = k; single_prec = sp; rnd_mode = rm;
    @(negedge clk);
  endtask

  task automatic expect_all(input string tag, input logic [63:0] f, input logic upd,
                            input logic fr, input logic fi, input logic [4:0] cls);
    chk({tag, " value"}, fp_out, f);
    chk({tag, " update"}, 64'(status_update), 64'(upd));
    chk({tag, " rounded"}, 64'(frac_rounded), 64'(fr));
    chk({tag, " inexact"}, 64'(frac_inexact), 64'(fi));
    chk({tag, " summary R6"}, 64'(inexact_sum), 64'(fi));
    chk({tag, " class"}, 64'(fp_class), 64'(cls));
  endtask

  task automatic t_zero;
    apply(64'd0, 2'd2, 1'b0, 2'd0);
    expect_all("R9 zero s64", 64'd0, 1, 0, 0, 5'b00010);
    apply(64'd0, 2'd0, 1'b0, 2'd0);
    expect_all("R2 zero s32", 64'd0, 0, 0, 0, 5'b00000);
  endtask

  task automatic t_narrow_exact;
    apply(64'hDEADBEEF_00000001, 2'd0, 1'b0, 2'd2);
    expect_all("R1 s32 one", 64'h3FF0000000000000, 0, 0, 0, 5'b0);
    apply(64'h12345678_FFFFFFFF, 2'd0, 1'b0, 2'd0);
    expect_all("R1 s32 minus one", 64'hBFF0000000000000, 0, 0, 0, 5'b0);
    apply(64'hFFFFFFFF_FFFFFFFF, 2'd1, 1'b0, 2'd3);
    expect_all("R2 u32 max", 64'h41EFFFFFFFE00000, 0, 0, 0, 5'b0);
    apply(64'h00000000_80000000, 2'd0, 1'b0, 2'd0);
    expect_all("R9 s32 min", 64'hC1E0000000000000, 0, 0, 0, 5'b0);
  endtask

  task automatic t_wide_modes;
    apply(64'h8000000000000000, 2'd2, 1'b0, 2'd0);
    expect_all("R9 s64 min", 64'hC3E0000000000000, 1, 0, 0, 5'b01000);
    apply(64'hFFFFFFFFFFFFFFFF, 2'd2, 1'b0, 2'd1);
    expect_all("R3 s64 minus one", 64'hBFF0000000000000, 1, 0, 0, 5'b01000);
    apply(64'hFFFFFFFFFFFFFFFF, 2'd3, 1'b0, 2'd0);
    expect_all("R10 u64 max rne", 64'h43F0000000000000, 1, 1, 1, 5'b00100);
    apply(64'hFFFFFFFFFFFFFFFF, 2'd3, 1'b0, 2'd1);
    expect_all("R4 u64 max rz", 64'h43EFFFFFFFFFFFFF, 1, 0, 1, 5'b00100);
    apply(64'hFFFFFFFFFFFFFFFF, 2'd3, 1'b0, 2'd2);
    expect_all("R4 u64 max up", 64'h43F0000000000000, 1, 1, 1, 5'b00100);
    apply(64'hFFFFFFFFFFFFFFFF, 2'd3, 1'b0, 2'd3);
    expect_all("R4 u64 max down", 64'h43EFFFFFFFFFFFFF, 1, 0, 1, 5'b00100);
  endtask

  task automatic t_ties;
    apply(64'h0020000000000001, 2'd3, 1'b0, 2'd0);
    expect_all("R4 tie even down", 64'h4340000000000000, 1, 0, 1, 5'b00100);
    apply(64'h0020000000000003, 2'd3, 1'b0, 2'd0);
    expect_all("R5 tie odd up", 64'h4340000000000002, 1, 1, 1, 5'b00100);
    apply(64'hFFDFFFFFFFFFFFFF, 2'd2, 1'b0, 2'd3);
    expect_all("R5 neg toward minus", 64'hC340000000000001, 1, 1, 1, 5'b01000);
    apply(64'hFFDFFFFFFFFFFFFF, 2'd2, 1'b0, 2'd2);
    expect_all("R4 neg toward plus", 64'hC340000000000000, 1, 0, 1, 5'b01000);
  endtask

  task automatic t_single;
    apply(64'hFFFFFFFF_01000001, 2'd1, 1'b1, 2'd0);
    expect_all("R7 single tie", 64'h4170000000000000, 1, 0, 1, 5'b00100);
    apply(64'h00000000_01000001, 2'd1, 1'b1, 2'd2);
    expect_all("R7 single up", 64'h4170000020000000, 1, 1, 1, 5'b00100);
    apply(64'h00000000_00000005, 2'd0, 1'b1, 2'd0);
    expect_all("R3 single exact", 64'h4014000000000000, 1, 0, 0, 5'b00100);
    apply(64'hFFFFFFFFFFFFFFFF, 2'd3, 1'b1, 2'd0);
    expect_all("R10 single carry", 64'h43F0000000000000, 1, 1, 1, 5'b00100);
    apply(64'hFFFFFFFFFFFFFFFF, 2'd3, 1'b1, 2'd1);
    expect_all("R7 single rz", 64'h43EFFFFFE0000000, 1, 0, 1, 5'b00100);
    apply(64'h00000000_FFFFFFFF, 2'd0, 1'b1, 2'd3);
    expect_all("R8 single neg one", 64'hBFF0000000000000, 1, 0, 0, 5'b01000);
  endtask

  initial begin
    int_in = 0; int_kind = 0; single_prec = 0; rnd_mode = 0;
    t_zero();
    t_narrow_exact();
    t_wide_modes();
    t_ties();
    t_single();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule